// File: doc/BRIEF.md
# Byte-Wide Host Port for a 16-bit Shared Memory

This block lets an external host with an 8-bit parallel bus read and write a 2K-word, 16-bit memory that an internal processor shares. The host sees three registers: control, address and data. Every 16-bit value moves as two byte transfers. A high/low select on each transfer says whether it is the first or the second byte of the pair. A control bit decides whether that first byte is the upper or the lower half of the word.

The data register comes in two flavours, chosen by the register-select lines. One advances the address after each word, for block transfers. The other keeps the address fixed, for single-word access. Two interrupt flags live in the control register, one in each direction. The internal processor has its own full-width port on the memory and its own flag controls.

A small pair state machine tracks each byte pair. Its states are:

- `ST_IDLE`: no pair is open.
- `ST_WPEND`: a first write byte is held.
- `ST_FETCH`: one cycle while the memory word is read.
- `ST_RPEND`: a word is latched and waits for its second byte to be read.

Its transitions are:

- A first-byte write moves to `ST_WPEND`.
- A second-byte write returns to `ST_IDLE` and commits the word.
- A first-byte read of data moves to `ST_FETCH`, then always on to `ST_RPEND`.
- A first-byte read of control or address goes straight to `ST_RPEND`.
- A second-byte read returns to `ST_IDLE`.

Host strobes arriving during `ST_FETCH` are ignored.

Top module: `hpi_port`

## Requirements
- R1: After reset, both interrupt outputs are 0, the address is 0, the byte-order bit is 0, `hp_rdata` is 0, and reading control and address returns 0.
- R2: `hp_sel` selects the register: 00 is control, 01 is data with address advance, 10 is address, 11 is data at a fixed address.
- R3: A byte with `hp_hilo`=0 is only held. The 16-bit word is written (to memory or to a register) on the edge that takes the byte with `hp_hilo`=1. Memory keeps its old value in between.
- R4: Control bit 0 sets the byte order for reads and writes of every register. With bit 0 = 1 the first byte (`hp_hilo`=0) is bits 15:8. With bit 0 = 0 the first byte is bits 7:0. A control write is split using the order in force before that write.
- R5: A read byte appears on `hp_rdata` in the cycle after its strobe and holds until the next read. The whole word is captured at the first byte, so a later memory change does not alter the second byte.
- R6: With select 01, the address advances by one after the second byte of each read or write, and wraps from 2047 to 0.
- R7: With select 11, the address is left unchanged by data reads and writes.
- R8: Writing control with bit 1 = 1 raises `cpu_irq`. Writing 0 there has no effect. A `cp_irq_ack` pulse clears it.
- R9: A `cp_irq_set` pulse raises `host_irq`. The host clears it by writing control with bit 2 = 1. Writing 0 there has no effect. If a set and a host clear fall in the same cycle, the set wins. Control reads back as {13 zeros, `host_irq`, `cpu_irq`, order}.
- R10: The internal port writes on the strobe edge and returns read data the cycle after `cp_en`. When the host commits and the internal port writes the same address in the same cycle, the internal value is stored.
- R11: The address register holds 11 bits. A write keeps bits 10:0, and a read returns the upper five bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_sel | input | 2 | Host register select |
| hp_hilo | input | 1 | 0 = first byte of pair, 1 = second byte |
| hp_wr | input | 1 | Host write strobe, one cycle per byte |
| hp_rd | input | 1 | Host read strobe, one cycle per byte |
| hp_wdata | input | 8 | Host write byte |
| hp_rdata | output | 8 | Host read byte |
| host_irq | output | 1 | Processor-to-host interrupt flag |
| cpu_irq | output | 1 | Host-to-processor interrupt flag |
| cp_en | input | 1 | Internal port access enable |
| cp_we | input | 1 | Internal port write enable |
| cp_addr | input | 11 | Internal port word address |
| cp_wdata | input | 16 | Internal port write word |
| cp_rdata | output | 16 | Internal port read word |
| cp_irq_set | input | 1 | Raise `host_irq` |
| cp_irq_ack | input | 1 | Clear `cpu_irq` |

## Verification
Every host byte strobe is held for one cycle, and `hp_rdata` is sampled at the falling edge after the rising edge that takes the strobe. For a first data byte this is the `ST_FETCH` cycle, where the byte comes straight from the memory output. Register effects, interrupt flags and memory commits all land on that same edge, so they are checked at the following falling edge. Internal-port reads are checked one full cycle after `cp_en`.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // control register bit positions
    localparam int CB_ORDER = 0;
    localparam int CB_H2C   = 1;
    localparam int CB_C2H   = 2;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_DATA_INC = 2'b01,
        SEL_ADDR     = 2'b10,
        SEL_DATA_FIX = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WPEND = 2'd1,
        ST_FETCH = 2'd2,
        ST_RPEND = 2'd3
    } pair_st_e;

    function automatic logic sel_is_data(input logic [1:0] s);
        return s[0];
    endfunction

    function automatic logic [BYTE_W-1:0] first_byte(input logic [WORD_W-1:0] w,
                                                     input logic hi_first);
        return hi_first ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] second_byte(input logic [WORD_W-1:0] w,
                                                      input logic hi_first);
        return hi_first ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
    endfunction

    function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] b0,
                                                     input logic [BYTE_W-1:0] b1,
                                                     input logic hi_first);
        return hi_first ? {b0, b1} : {b1, b0};
    endfunction

endpackage

// File: rtl/hpi_dpram.sv
module hpi_dpram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wd,
    output logic [DATA_W-1:0] a_rd,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // port B is written last, so it wins a same-address collision
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wd;
        if (b_en && b_we) mem[b_addr] <= b_wd;
        if (a_en) a_rd <= mem[a_addr];
        if (b_en) b_rd <= mem[b_addr];
    end
endmodule

// File: rtl/hpi_pair_fsm.sv
module hpi_pair_fsm
    import hpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_wr,
    input  logic              hp_rd,
    input  logic              hp_hilo,
    input  logic [1:0]        hp_sel,
    input  logic [BYTE_W-1:0] hp_wdata,
    input  logic              hi_first,
    output pair_st_e          st_o,
    output logic              wr_commit,
    output logic              rd_first,
    output logic              rd_second,
    output logic [WORD_W-1:0] commit_word
);
    pair_st_e          state_q, state_d;
    logic [BYTE_W-1:0] hold_q;
    logic              busy;

    assign busy = (state_q == ST_FETCH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // held first write byte
    always_ff @(posedge clk) begin
        if (!rst_n)                             hold_q <= '0;
        else if (hp_wr && !hp_hilo && !busy)    hold_q <= hp_wdata;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_RPEND;
            ST_IDLE, ST_WPEND, ST_RPEND: begin
                if (hp_wr)
                    state_d = hp_hilo ? ST_IDLE : ST_WPEND;
                else if (hp_rd) begin
                    if (hp_hilo)                 state_d = ST_IDLE;
                    else if (sel_is_data(hp_sel)) state_d = ST_FETCH;
                    else                         state_d = ST_RPEND;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        st_o        = state_q;
        wr_commit   = hp_wr && hp_hilo && !busy;
        rd_first    = hp_rd && !hp_wr && !hp_hilo && !busy;
        rd_second   = hp_rd && !hp_wr && hp_hilo && !busy;
        commit_word = join_bytes(hold_q, hp_wdata, hi_first);
    end
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
    import hpi_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic              rd_second,
    input  logic [1:0]        hp_sel,
    input  logic [WORD_W-1:0] word,
    input  logic              cp_irq_set,
    input  logic              cp_irq_ack,
    output logic [ADDR_W-1:0] addr_q,
    output logic              hi_first,
    output logic              h2c,
    output logic              c2h,
    output logic [WORD_W-1:0] ctrl_rd,
    output logic [WORD_W-1:0] addr_rd
);
    localparam int PAD_C = WORD_W - 3;
    localparam int PAD_A = WORD_W - ADDR_W;

    logic ctrl_wr, addr_wr, step;

    always_comb begin
        ctrl_wr = wr_commit && (hp_sel == SEL_CTRL);
        addr_wr = wr_commit && (hp_sel == SEL_ADDR);
        step    = (wr_commit || rd_second) && (hp_sel == SEL_DATA_INC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            hi_first <= 1'b0;
            h2c      <= 1'b0;
            c2h      <= 1'b0;
        end else begin
            if (addr_wr)   addr_q <= word[ADDR_W-1:0];
            else if (step) addr_q <= addr_q + 1'b1;
            if (ctrl_wr) hi_first <= word[CB_ORDER];
            if (ctrl_wr && word[CB_H2C]) h2c <= 1'b1;
            else if (cp_irq_ack)         h2c <= 1'b0;
            if (cp_irq_set)                  c2h <= 1'b1;
            else if (ctrl_wr && word[CB_C2H]) c2h <= 1'b0;
        end
    end

    assign ctrl_rd = {{PAD_C{1'b0}}, c2h, h2c, hi_first};
    assign addr_rd = {{PAD_A{1'b0}}, addr_q};
endmodule

// File: rtl/hpi_port.sv
module hpi_port
    import hpi_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hp_sel,
    input  logic              hp_hilo,
    input  logic              hp_wr,
    input  logic              hp_rd,
    input  logic [7:0]        hp_wdata,
    output logic [7:0]        hp_rdata,
    output logic              host_irq,
    output logic              cpu_irq,
    input  logic              cp_en,
    input  logic              cp_we,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [15:0]       cp_wdata,
    output logic [15:0]       cp_rdata,
    input  logic              cp_irq_set,
    input  logic              cp_irq_ack
);
    pair_st_e          fsm_state;
    logic [ADDR_W-1:0] addr_now;
    logic              wr_commit, rd_first, rd_second, hi_first;
    logic [WORD_W-1:0] commit_word, ctrl_rd, addr_rd, reg_word, mem_q, hw_q;
    logic [BYTE_W-1:0] out_q;
    logic              ram_en, ram_we, fetching;

    hpi_pair_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hp_wr(hp_wr), .hp_rd(hp_rd),
        .hp_hilo(hp_hilo), .hp_sel(hp_sel), .hp_wdata(hp_wdata),
        .hi_first(hi_first), .st_o(fsm_state), .wr_commit(wr_commit),
        .rd_first(rd_first), .rd_second(rd_second), .commit_word(commit_word)
    );

    hpi_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .rd_second(rd_second),
        .hp_sel(hp_sel), .word(commit_word), .cp_irq_set(cp_irq_set),
        .cp_irq_ack(cp_irq_ack), .addr_q(addr_now), .hi_first(hi_first),
        .h2c(cpu_irq), .c2h(host_irq), .ctrl_rd(ctrl_rd), .addr_rd(addr_rd)
    );

    always_comb begin
        ram_we   = wr_commit && sel_is_data(hp_sel);
        ram_en   = ram_we || (rd_first && sel_is_data(hp_sel));
        fetching = (fsm_state == ST_FETCH);
        reg_word = (hp_sel == SEL_CTRL) ? ctrl_rd : addr_rd;
    end

    hpi_dpram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
        .clk(clk),
        .a_en(ram_en), .a_we(ram_we), .a_addr(addr_now), .a_wd(commit_word), .a_rd(mem_q),
        .b_en(cp_en), .b_we(cp_we), .b_addr(cp_addr), .b_wd(cp_wdata), .b_rd(cp_rdata)
    );

    // read word latch and byte output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q  <= '0;
            out_q <= '0;
        end else if (rd_first && !sel_is_data(hp_sel)) begin
            hw_q  <= reg_word;
            out_q <= first_byte(reg_word, hi_first);
        end else if (fetching) begin
            hw_q  <= mem_q;
            out_q <= first_byte(mem_q, hi_first);
        end else if (rd_second) begin
            out_q <= second_byte(hw_q, hi_first);
        end
    end

    assign hp_rdata = fetching ? first_byte(mem_q, hi_first) : out_q;
endmodule

// File: rtl/hpi_port_chk.sv
module hpi_port_chk
    import hpi_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        hp_sel,
    input logic              hp_hilo,
    input logic              hp_wr,
    input logic              hp_rd,
    input logic [7:0]        hp_rdata,
    input logic              host_irq,
    input logic              cpu_irq,
    input logic              cp_irq_set,
    input logic              cp_irq_ack,
    input pair_st_e          fsm_state,
    input logic [ADDR_W-1:0] addr_now
);
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_irq_set |=> host_irq); // R9

    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_irq_ack && !hp_wr) |=> !cpu_irq); // R8

    AST_FETCH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FETCH) |=> (fsm_state == ST_RPEND)); // R5

    AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((hp_rd || hp_wr) && hp_hilo && hp_sel == 2'b01 && fsm_state != ST_FETCH)
        |=> (addr_now == ADDR_W'($past(addr_now) + 1'b1))); // R6

    AST_FIXED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((hp_rd || hp_wr) && hp_hilo && hp_sel == 2'b11 && fsm_state != ST_FETCH)
        |=> $stable(addr_now)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_rd && !hp_wr && fsm_state != ST_FETCH) |=> $stable(hp_rdata)); // R5
endmodule

bind hpi_port hpi_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hp_sel(hp_sel), .hp_hilo(hp_hilo),
    .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_rdata(hp_rdata), .host_irq(host_irq),
    .cpu_irq(cpu_irq), .cp_irq_set(cp_irq_set), .cp_irq_ack(cp_irq_ack),
    .fsm_state(fsm_state), .addr_now(addr_now)
);

// File: tb/hpi_port_test.sv
module hpi_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int BLK = 32;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    hp_sel = 0;
    logic          hp_hilo = 0, hp_wr = 0, hp_rd = 0;
    logic [7:0]    hp_wdata = 0;
    logic [7:0]    hp_rdata;
    logic          host_irq, cpu_irq;
    logic          cp_en = 0, cp_we = 0;
    logic [AW-1:0] cp_addr = 0;
    logic [15:0]   cp_wdata = 0;
    logic [15:0]   cp_rdata;
    logic          cp_irq_set = 0, cp_irq_ack = 0;

    int  vectors = 0;
    int  miscompares = 0;
    logic ord = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpi_port #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .hp_sel(hp_sel), .hp_hilo(hp_hilo),
        .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
        .host_irq(host_irq), .cpu_irq(cpu_irq), .cp_en(cp_en), .cp_we(cp_we),
        .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .cp_irq_set(cp_irq_set), .cp_irq_ack(cp_irq_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] s, input logic hl, input logic [7:0] b);
        @(negedge clk);
        hp_sel = s; hp_hilo = hl; hp_wdata = b; hp_wr = 1;
        @(negedge clk);
        hp_wr = 0;
    endtask

    task automatic rd_byte(input logic [1:0] s, input logic hl, output logic [7:0] b);
        @(negedge clk);
        hp_sel = s; hp_hilo = hl; hp_rd = 1;
        @(negedge clk);
        hp_rd = 0;
        b = hp_rdata;
    endtask

    task automatic wr_word(input logic [1:0] s, input logic [15:0] w);
        wr_byte(s, 0, ord ? w[15:8] : w[7:0]);
        wr_byte(s, 1, ord ? w[7:0] : w[15:8]);
        if (s == 2'b00) ord = w[0];
    endtask

    task automatic rd_word(input logic [1:0] s, output logic [15:0] w);
        logic [7:0] b0, b1;
        rd_byte(s, 0, b0);
        rd_byte(s, 1, b1);
        w = ord ? {b0, b1} : {b1, b0};
    endtask

    task automatic cp_wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        cp_en = 1; cp_we = 1; cp_addr = a; cp_wdata = d;
        @(negedge clk);
        cp_en = 0; cp_we = 0;
    endtask

    task automatic cp_rd(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        cp_en = 1; cp_we = 0; cp_addr = a;
        @(negedge clk);
        cp_en = 0;
        d = cp_rdata;
    endtask

    function automatic logic [15:0] pat(input int i, input int o);
        return 16'(i * 16'h1357 + o * 16'h0F0F + 16'h2468);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [15:0] w;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", hp_rdata, 0);
        check("R1 host_irq", host_irq, 0);
        check("R1 cpu_irq", cpu_irq, 0);
        rd_word(2'b00, w); check("R1 ctrl", w, 0);
        rd_word(2'b10, w); check("R1 addr", w, 0);

        // R11 R2 address register width
        wr_word(2'b10, 16'hFA5C);
        rd_word(2'b10, w); check("R11 addr readback", w, 16'h025C);

        // R4 R6 block sweep in both byte orders
        for (int o = 0; o < 2; o++) begin
            wr_word(2'b00, 16'(o));
            wr_word(2'b10, 16'h0080);
            for (int i = 0; i < BLK; i++) wr_word(2'b01, pat(i, o));
            rd_word(2'b10, w); check("R6 addr after block write", w, 16'h0080 + BLK);
            for (int i = 0; i < BLK; i++) begin
                cp_rd(AW'(16'h0080 + i), w); check("R4 word via cp", w, pat(i, o));
            end
            wr_word(2'b10, 16'h0080);
            for (int i = 0; i < BLK; i++) begin
                rd_word(2'b01, w); check("R6 block read", w, pat(i, o));
            end
            rd_word(2'b10, w); check("R6 addr after block read", w, 16'h0080 + BLK);
        end

        // R7 fixed address
        wr_word(2'b10, 16'h0100);
        wr_word(2'b11, 16'hBEEF);
        rd_word(2'b10, w); check("R7 addr after fixed write", w, 16'h0100);
        rd_word(2'b11, w); check("R7 fixed read", w, 16'hBEEF);
        rd_word(2'b10, w); check("R7 addr after fixed read", w, 16'h0100);

        // R3 commit on second byte (order high first)
        wr_word(2'b00, 16'h0001);
        cp_wr(11'h200, 16'h1111);
        wr_word(2'b10, 16'h0200);
        wr_byte(2'b11, 0, 8'hAA);
        cp_rd(11'h200, w); check("R3 mid pair unchanged", w, 16'h1111);
        wr_byte(2'b11, 1, 8'h55);
        cp_rd(11'h200, w); check("R3 committed", w, 16'hAA55);

        // R5 word latched at first byte, latency, hold
        cp_wr(11'h300, 16'h1234);
        wr_word(2'b10, 16'h0300);
        rd_byte(2'b11, 0, b); check("R5 first byte", b, 8'h12);
        cp_wr(11'h300, 16'h9999);
        rd_byte(2'b11, 1, b); check("R5 latched second byte", b, 8'h34);
        repeat (3) @(negedge clk);
        check("R5 rdata held", hp_rdata, 8'h34);

        // R4 read order of the same word
        cp_wr(11'h050, 16'hA1B2);
        wr_word(2'b10, 16'h0050);
        rd_byte(2'b11, 0, b); check("R4 order1 first", b, 8'hA1);
        rd_byte(2'b11, 1, b);
        wr_word(2'b00, 16'h0000);
        rd_byte(2'b11, 0, b); check("R4 order0 first", b, 8'hB2);
        rd_byte(2'b11, 1, b); check("R4 order0 second", b, 8'hA1);

        // R6 wrap
        wr_word(2'b10, 16'h07FF);
        wr_word(2'b01, 16'h0A0B);
        rd_word(2'b10, w); check("R6 wrap", w, 0);
        cp_rd(11'h7FF, w); check("R6 wrap data", w, 16'h0A0B);

        // R10 collision, internal port wins
        wr_word(2'b00, 16'h0001);
        wr_word(2'b10, 16'h0040);
        wr_byte(2'b11, 0, 8'h11);
        @(negedge clk);
        hp_sel = 2'b11; hp_hilo = 1; hp_wdata = 8'h22; hp_wr = 1;
        cp_en = 1; cp_we = 1; cp_addr = 11'h040; cp_wdata = 16'hC0DE;
        @(negedge clk);
        hp_wr = 0; cp_en = 0; cp_we = 0;
        cp_rd(11'h040, w); check("R10 collision cp view", w, 16'hC0DE);
        rd_word(2'b11, w); check("R10 collision host view", w, 16'hC0DE);

        // R8 host-to-processor flag
        wr_word(2'b00, 16'h0003);
        check("R8 raise", cpu_irq, 1);
        rd_word(2'b00, w); check("R8 ctrl readback", w, 16'h0003);
        wr_word(2'b00, 16'h0001);
        check("R8 zero no effect", cpu_irq, 1);
        @(negedge clk); cp_irq_ack = 1; @(negedge clk); cp_irq_ack = 0;
        check("R8 ack clears", cpu_irq, 0);

        // R9 processor-to-host flag
        @(negedge clk); cp_irq_set = 1; @(negedge clk); cp_irq_set = 0;
        check("R9 raise", host_irq, 1);
        rd_word(2'b00, w); check("R9 ctrl readback", w, 16'h0005);
        wr_word(2'b00, 16'h0001);
        check("R9 zero no effect", host_irq, 1);
        wr_word(2'b00, 16'h0005);
        check("R9 host clear", host_irq, 0);
        wr_byte(2'b00, 0, 8'h00);
        @(negedge clk);
        hp_sel = 2'b00; hp_hilo = 1; hp_wdata = 8'h05; hp_wr = 1; cp_irq_set = 1;
        @(negedge clk);
        hp_wr = 0; cp_irq_set = 0;
        check("R9 set wins", host_irq, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule